// File: doc/BRIEF.md
# Indexed Host Register Port for a Video Subsystem

This block gives a host CPU two 16-bit locations through which it reaches every device inside a video subsystem. Location 0 holds a control word that names a target device, a starting index and the direction in which an internal pointer moves. Location 1 (host offset 2) is a data window. Every read or write of the window is sent to the selected device at the pointer's current value, and the pointer then moves up, moves down or stays put.

Four devices sit behind the port: the block transfer engine, the timing generator, the colour table and the framebuffer. The first three are indexed by an 8-bit pointer. The framebuffer uses a 24-bit address and is set up in two steps. The control word supplies address bits 23:16. The next data write does not reach memory; it supplies bits 15:0. After that, data moves normally.

A data write to index 0 of the block transfer engine also raises a one-cycle reset request to the rest of the subsystem.

Top module: `vidhost_port`

## Requirements
- R1: After reset, reading location 0 (`host_loc`=0) returns `{blt_done, 15'h0000}`. The pointer is 0, and the block transfer engine with count hold is selected.
- R2: Reading location 0 returns bit 15 = `blt_done`, bits 14:13 = 0, bits 12:11 = count code, bits 10:9 = device code, bit 8 = 0 and bits 7:0 = the start index. A write to bit 15 has no effect.
- R3: Device codes are 0 for the block transfer engine, 1 for the timing generator, 2 for the colour table and 3 for the framebuffer. A data access raises exactly the `dev_wr` or `dev_rd` bit whose number is the device code. A data read returns that device's read-data input on `host_rdata`.
- R4: With count code 01, the pointer increases by one after each data access.
- R5: With count code 10, the pointer decreases by one after each data access.
- R6: With count code 00, and with the illegal code 11, the pointer does not change on data accesses.
- R7: For devices 0 to 2, the pointer is `{16'h0000, start}` after a control write and wraps modulo 256, so `dev_addr` bits 23:8 stay 0.
- R8: With device 3 selected, a control write sets `dev_addr` to `{start, 16'h0000}`. The first following data write raises no `dev_wr` bit and sets `dev_addr[15:0]` to the written word without stepping the pointer. Later data writes reach the framebuffer.
- R9: For device 3, the pointer steps over the full 24 bits and wraps modulo 2^24.
- R10: `subsys_rst` is 1 in the cycle after a data write that reaches device 0 at index 0, and is 0 otherwise.
- R11: Every control write reloads the pointer from its start field. When the device code is 3, it also re-arms the capture of the low address word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one access per cycle |
| host_rd | input | 1 | Host read strobe; ignored while `host_wr` is high |
| host_loc | input | 1 | 0 selects the control word, 1 selects the data window |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data (combinational) |
| blt_done | input | 1 | Done flag from the block transfer engine |
| dev_wr | output | 4 | One-hot device write strobe, indexed by device code |
| dev_rd | output | 4 | One-hot device read strobe, indexed by device code |
| dev_addr | output | 24 | Current pointer |
| dev_wdata | output | 16 | Write data to the devices |
| blt_rdata | input | 16 | Read data from the block transfer engine |
| sync_rdata | input | 16 | Read data from the timing generator |
| clut_rdata | input | 16 | Read data from the colour table |
| vmem_rdata | input | 16 | Read data from the framebuffer |
| subsys_rst | output | 1 | One-cycle reset request to the subsystem |

## Verification
The assertions assume the host raises at most one of `host_wr` and `host_rd` in a cycle, and that the device read-data inputs answer combinationally to `dev_addr`. The stimulus never raises both strobes, drives all inputs half a cycle away from the sampling edge, and models each device's read data as a fixed function of the address. The assertions make no assumption about `blt_done`, so the stimulus changes it freely between control writes.

// File: rtl/vhp_pkg.sv
// Shared codes and field positions for the indexed host register port.
// Assumes a 16-bit host word; the bit positions below are decoded by host software.
package vhp_pkg;

    typedef enum logic [1:0] {
        DEV_BLT  = 2'd0,
        DEV_SYNC = 2'd1,
        DEV_CLUT = 2'd2,
        DEV_VMEM = 2'd3
    } dev_e;

    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_UP   = 2'd1,
        CNT_DOWN = 2'd2,
        CNT_BAD  = 2'd3
    } cnt_e;

    localparam int DONE_BIT = 15;
    localparam int CNT_LSB  = 11;
    localparam int DEV_LSB  = 9;
    localparam int NUM_DEV  = 4;

endpackage

// File: rtl/vhp_mode.sv
// Holds the control word fields and the framebuffer low-address capture flag.
// Assumes mode_wr and data_wr are never high together (they decode one location each).
module vhp_mode
    import vhp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int REG_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] wdata,
    output dev_e              dev,
    output cnt_e              cnt,
    output logic [REG_AW-1:0] base,
    output logic              armed
);

    // Capture control fields on a control write; clear capture flag on first data write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev   <= DEV_BLT;
            cnt   <= CNT_HOLD;
            base  <= '0;
            armed <= 1'b0;
        end else if (mode_wr) begin
            dev   <= dev_e'(wdata[DEV_LSB +: 2]);
            cnt   <= cnt_e'(wdata[CNT_LSB +: 2]);
            base  <= wdata[REG_AW-1:0];
            armed <= (wdata[DEV_LSB +: 2] == 2'(DEV_VMEM));
        end else if (data_wr && armed) begin
            armed <= 1'b0;
        end
    end

    // R11: a framebuffer control write leaves the capture armed
    a_r11_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && wdata[DEV_LSB +: 2] == 2'(DEV_VMEM)) |=> armed);

    // R8: capture is consumed by exactly one data write
    a_r8_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && armed && !mode_wr) |=> !armed);

endmodule

// File: rtl/vhp_ptr.sv
// Internal address pointer: loaded by control writes, low half captured for the
// framebuffer, stepped by data accesses with a per-device wrap width.
// Assumes mode_wr, capture and step are mutually exclusive.
module vhp_ptr
    import vhp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int REG_AW = 8,
    parameter int FB_AW  = REG_AW + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic              capture,
    input  logic              step,
    input  logic [DATA_W-1:0] wdata,
    input  dev_e              dev,
    input  cnt_e              cnt,
    output logic [FB_AW-1:0]  ptr
);

    localparam int HI_W = FB_AW - REG_AW;

    logic [FB_AW-1:0]  ptr_inc;
    logic [FB_AW-1:0]  ptr_dec;
    logic [FB_AW-1:0]  ptr_load;
    logic [REG_AW-1:0] lo_inc;
    logic [REG_AW-1:0] lo_dec;

    // Next-value candidates: full-width for the framebuffer, index-width otherwise.
    always_comb begin
        lo_inc = ptr[REG_AW-1:0] + 1'b1;
        lo_dec = ptr[REG_AW-1:0] - 1'b1;
        if (dev == DEV_VMEM) begin
            ptr_inc = ptr + 1'b1;
            ptr_dec = ptr - 1'b1;
        end else begin
            ptr_inc = {{HI_W{1'b0}}, lo_inc};
            ptr_dec = {{HI_W{1'b0}}, lo_dec};
        end
    end

    // Load value from a control write: framebuffer start goes into the top byte.
    always_comb begin
        if (wdata[DEV_LSB +: 2] == 2'(DEV_VMEM))
            ptr_load = {wdata[REG_AW-1:0], {DATA_W{1'b0}}};
        else
            ptr_load = {{HI_W{1'b0}}, wdata[REG_AW-1:0]};
    end

    // Pointer register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (mode_wr) begin
            ptr <= ptr_load;
        end else if (capture) begin
            ptr <= {ptr[FB_AW-1:DATA_W], wdata};
        end else if (step) begin
            case (cnt)
                CNT_UP:   ptr <= ptr_inc;
                CNT_DOWN: ptr <= ptr_dec;
                default:  ptr <= ptr;
            endcase
        end
    end

    // R6: hold and the illegal code both leave the pointer unchanged
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (cnt == CNT_HOLD || cnt == CNT_BAD)) |=> $stable(ptr));

    // R4: index devices count up by one within the index width
    a_r4_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt == CNT_UP && dev != DEV_VMEM) |=>
        ptr[REG_AW-1:0] == REG_AW'($past(ptr[REG_AW-1:0]) + 1'b1));

    // R9: framebuffer counts down across the full address width
    a_r9_fb_down: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt == CNT_DOWN && dev == DEV_VMEM) |=>
        ptr == FB_AW'($past(ptr) - 1'b1));

    // R7: index devices never see upper address bits
    a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (dev != DEV_VMEM) |-> ptr[FB_AW-1:REG_AW] == '0);

    // R8: a capture write sets only the low half and keeps the top byte
    a_r8_capture_hi: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> ptr[FB_AW-1:DATA_W] == $past(ptr[FB_AW-1:DATA_W]));

endmodule

// File: rtl/vhp_route.sv
// Decodes host strobes into control, capture and device accesses, selects read
// data, and registers the subsystem reset request.
// Assumes read data from devices is valid combinationally for the current pointer.
module vhp_route
    import vhp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int REG_AW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic               host_loc,
    input  logic               blt_done,
    input  dev_e               dev,
    input  cnt_e               cnt,
    input  logic [REG_AW-1:0]  base,
    input  logic               armed,
    input  logic [REG_AW-1:0]  ptr_lo,
    input  logic [DATA_W-1:0]  rd_blt,
    input  logic [DATA_W-1:0]  rd_sync,
    input  logic [DATA_W-1:0]  rd_clut,
    input  logic [DATA_W-1:0]  rd_vmem,
    output logic               mode_wr,
    output logic               data_wr,
    output logic               capture,
    output logic               step,
    output logic [NUM_DEV-1:0] dev_wr,
    output logic [NUM_DEV-1:0] dev_rd,
    output logic [DATA_W-1:0]  host_rdata,
    output logic               rst_req
);

    localparam int PAD_W = DEV_LSB - REG_AW;

    logic data_rd;
    logic pass_wr;
    logic [DATA_W-1:0] mode_view;
    logic [DATA_W-1:0] win_view;

    // Strobe decode; a write wins over a simultaneous read.
    always_comb begin
        mode_wr = host_wr & ~host_loc;
        data_wr = host_wr & host_loc;
        data_rd = host_rd & ~host_wr & host_loc;
        capture = data_wr & armed;
        pass_wr = data_wr & ~armed;
        step    = pass_wr | data_rd;
    end

    // One-hot device strobes, one generated lane per device code.
    for (genvar g = 0; g < NUM_DEV; g++) begin : g_lane
        assign dev_wr[g] = pass_wr & (dev == dev_e'(g));
        assign dev_rd[g] = data_rd & (dev == dev_e'(g));
    end

    // Assemble the control word view and the data window view.
    always_comb begin
        mode_view = '0;
        mode_view[DONE_BIT]       = blt_done;
        mode_view[CNT_LSB +: 2]   = cnt;
        mode_view[DEV_LSB +: 2]   = dev;
        mode_view[REG_AW-1:0]     = base;
        mode_view[REG_AW +: PAD_W] = '0;
        case (dev)
            DEV_BLT:  win_view = rd_blt;
            DEV_SYNC: win_view = rd_sync;
            DEV_CLUT: win_view = rd_clut;
            default:  win_view = rd_vmem;
        endcase
        host_rdata = host_loc ? win_view : mode_view;
    end

    // Register the reset request raised by a write to engine index 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rst_req <= 1'b0;
        else
            rst_req <= pass_wr && dev == DEV_BLT && ptr_lo == '0;
    end

    // R3: at most one device is written per cycle
    a_r3_wr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_wr));

    // R3: at most one device is read per cycle
    a_r3_rd_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_rd));

    // R8: the low-address capture write reaches no device
    a_r8_capture_silent: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> dev_wr == '0);

    // R10: reset request follows an engine write at index 0
    a_r10_rst_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_wr[DEV_BLT] && ptr_lo == '0) |=> rst_req);

endmodule

// File: rtl/vidhost_port.sv
// Two-location host port into a video subsystem: a control word picks device,
// start index and count direction; a data window moves words to the device.
// Assumes one host access per cycle and combinational device read data.
module vidhost_port
    import vhp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int REG_AW = 8,
    localparam int FB_AW = REG_AW + DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic               host_loc,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    input  logic               blt_done,
    output logic [NUM_DEV-1:0] dev_wr,
    output logic [NUM_DEV-1:0] dev_rd,
    output logic [FB_AW-1:0]   dev_addr,
    output logic [DATA_W-1:0]  dev_wdata,
    input  logic [DATA_W-1:0]  blt_rdata,
    input  logic [DATA_W-1:0]  sync_rdata,
    input  logic [DATA_W-1:0]  clut_rdata,
    input  logic [DATA_W-1:0]  vmem_rdata,
    output logic               subsys_rst
);

    dev_e              dev;
    cnt_e              cnt;
    logic [REG_AW-1:0] base;
    logic              armed;
    logic              mode_wr;
    logic              data_wr;
    logic              capture;
    logic              step;
    logic [FB_AW-1:0]  ptr;

    vhp_mode #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_wr (mode_wr),
        .data_wr (data_wr),
        .wdata   (host_wdata),
        .dev     (dev),
        .cnt     (cnt),
        .base    (base),
        .armed   (armed)
    );

    vhp_ptr #(.DATA_W(DATA_W), .REG_AW(REG_AW), .FB_AW(FB_AW)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_wr (mode_wr),
        .capture (capture),
        .step    (step),
        .wdata   (host_wdata),
        .dev     (dev),
        .cnt     (cnt),
        .ptr     (ptr)
    );

    vhp_route #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_loc   (host_loc),
        .blt_done   (blt_done),
        .dev        (dev),
        .cnt        (cnt),
        .base       (base),
        .armed      (armed),
        .ptr_lo     (ptr[REG_AW-1:0]),
        .rd_blt     (blt_rdata),
        .rd_sync    (sync_rdata),
        .rd_clut    (clut_rdata),
        .rd_vmem    (vmem_rdata),
        .mode_wr    (mode_wr),
        .data_wr    (data_wr),
        .capture    (capture),
        .step       (step),
        .dev_wr     (dev_wr),
        .dev_rd     (dev_rd),
        .host_rdata (host_rdata),
        .rst_req    (subsys_rst)
    );

    assign dev_addr  = ptr;
    assign dev_wdata = host_wdata;

endmodule

// File: tb/sim_vidhost_port.sv
module sim_vidhost_port;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_wr, host_rd, host_loc;
    logic [15:0] host_wdata;
    logic [15:0] host_rdata;
    logic        blt_done;
    logic [3:0]  dev_wr, dev_rd;
    logic [23:0] dev_addr;
    logic [15:0] dev_wdata;
    logic [15:0] blt_rdata, sync_rdata, clut_rdata, vmem_rdata;
    logic        subsys_rst;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;
    bit rst_exp = 0;

    always #(CLK_P/2) clk = ~clk;

    // Device read data modelled as fixed functions of the address.
    assign blt_rdata  = 16'hB000 ^ dev_addr[15:0];
    assign sync_rdata = 16'h5100 ^ dev_addr[15:0];
    assign clut_rdata = 16'hC200 ^ dev_addr[15:0];
    assign vmem_rdata = dev_addr[23:8] ^ 16'h0F0F;

    vidhost_port u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_loc(host_loc), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .blt_done(blt_done), .dev_wr(dev_wr), .dev_rd(dev_rd),
        .dev_addr(dev_addr), .dev_wdata(dev_wdata), .blt_rdata(blt_rdata),
        .sync_rdata(sync_rdata), .clut_rdata(clut_rdata),
        .vmem_rdata(vmem_rdata), .subsys_rst(subsys_rst)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] nxt(input logic [23:0] p, input int c, input bit fb);
        logic [23:0] r;
        r = p;
        if (c == 1) r = p + 24'd1;
        if (c == 2) r = p - 24'd1;
        if (!fb) r = {16'h0, r[7:0]};
        return r;
    endfunction

    // Drive one access at the falling edge, check the reset pulse from the previous one.
    task automatic start_op(input bit wr, input bit rd, input bit loc, input logic [15:0] w);
        @(negedge clk);
        check("R10 subsys_rst", subsys_rst, rst_exp);
        rst_exp  = 0;
        host_wr  = wr;
        host_rd  = rd;
        host_loc = loc;
        host_wdata = w;
        #1;
    endtask

    task automatic idle();
        start_op(0, 0, 0, 16'h0);
    endtask

    task automatic sweep_regs();
        for (int d = 0; d < 3; d++) begin
            for (int c = 0; c < 4; c++) begin
                for (int b = 0; b < 4; b++) begin
                    logic [7:0]  base;
                    logic [15:0] mw;
                    logic [23:0] ep;
                    base = (b == 0) ? 8'h00 : (b == 1) ? 8'h01 : (b == 2) ? 8'h80 : 8'hFF;
                    mw = {1'b1, 2'b11, c[1:0], d[1:0], 1'b1, base};
                    blt_done = b[0];
                    start_op(1, 0, 0, mw);
                    @(posedge clk);
                    start_op(0, 1, 0, 16'h0);
                    check("R2 mode readback", host_rdata,
                          {b[0], 2'b00, c[1:0], d[1:0], 1'b0, base});
                    check("R7 pointer load", dev_addr, {16'h0, base});
                    @(posedge clk);
                    ep = {16'h0, base};
                    for (int k = 0; k < 3; k++) begin
                        start_op(1, 0, 1, 16'hA5A0 + 16'(k));
                        check((c == 0 || c == 3) ? "R6 hold addr" :
                              (c == 1) ? "R4 up addr" : "R5 down addr", dev_addr, ep);
                        check("R3 write strobe", dev_wr, 4'b1 << d);
                        rst_exp = (d == 0 && ep == 24'h0);
                        @(posedge clk);
                        ep = nxt(ep, c, 0);
                    end
                    start_op(0, 1, 1, 16'h0);
                    check("R3 read strobe", dev_rd, 4'b1 << d);
                    check("R3 read data", host_rdata,
                          (d == 0 ? 16'hB000 : d == 1 ? 16'h5100 : 16'hC200) ^ ep[15:0]);
                    check("R7 wrap addr", dev_addr, ep);
                    @(posedge clk);
                    ep = nxt(ep, c, 0);
                    idle();
                    check("R7 after read", dev_addr, ep);
                end
            end
        end
    endtask

    task automatic sweep_fb();
        for (int c = 0; c < 4; c++) begin
            for (int h = 0; h < 3; h++) begin
                for (int l = 0; l < 3; l++) begin
                    logic [7:0]  hi;
                    logic [15:0] lo;
                    logic [23:0] ep;
                    hi = (h == 0) ? 8'h00 : (h == 1) ? 8'h12 : 8'hFF;
                    lo = (l == 0) ? 16'h0000 : (l == 1) ? 16'hFFFF : 16'h8000;
                    start_op(1, 0, 0, {3'b000, c[1:0], 2'b11, 1'b0, hi});
                    @(posedge clk);
                    start_op(1, 0, 1, lo);
                    check("R11 fb reload", dev_addr, {hi, 16'h0});
                    check("R8 capture silent", dev_wr, 4'b0000);
                    @(posedge clk);
                    ep = {hi, lo};
                    for (int k = 0; k < 2; k++) begin
                        start_op(1, 0, 1, 16'h1234);
                        check("R8 fb addr", dev_addr, ep);
                        check("R8 fb write", dev_wr, 4'b1000);
                        @(posedge clk);
                        ep = nxt(ep, c, 1);
                    end
                    start_op(0, 1, 1, 16'h0);
                    check("R9 fb addr", dev_addr, ep);
                    check("R3 fb read", host_rdata, ep[23:8] ^ 16'h0F0F);
                    @(posedge clk);
                end
            end
        end
        idle();
    endtask

    initial begin
        host_wr = 0; host_rd = 0; host_loc = 0; host_wdata = 0;
        blt_done = 1'b1;
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        check("R1 reset mode", host_rdata, 16'h8000);
        check("R1 reset addr", dev_addr, 24'h0);
        blt_done = 1'b0;
        #1;
        check("R2 done flag", host_rdata, 16'h0000);
        sweep_regs();
        sweep_fb();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            done = 1;
            n_vec++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule